// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of parallel stereo sample pairs into one serial data line. Each frame carries a left word and then a right word of `WORD_W` (24) bits, two's complement, most significant bit first. The block can act as the bit-clock and word-clock source, deriving both from the system clock. It can also follow a bit clock and a word clock supplied from outside, which it synchronises into the system clock domain. Frames of 48 or 64 bit clocks are accepted.

Two framings are supported. In left-justified framing the MSB follows the word-clock edge directly. In I2S framing it comes one bit clock later. The framing is not set by a register. While the block leaves its data pin undriven after reset, it reads the level that a pull resistor gives that pin, and it keeps that level as its framing choice. A producer offers a pair with a one-cycle strobe. The pair waits in a pending register. It moves into the transmit holding register when a left word begins, and an acknowledge pulse reports that move. If no pair has arrived by then, the previous pair is sent again.

Top module: `stereo_ser_tx`

## Requirements
- R1: Every frame sends the captured left word and then the captured right word, each WORD_W bits, MSB first, one bit per bit-clock period.
- R2: Left-justified framing (strap low): the MSB is driven on the first bit-clock falling edge after a word-clock change, and the left word is sent while the word clock is high.
- R3: I2S framing (strap high): the MSB is driven one bit clock later than in R2, and the left word is sent while the word clock is low.
- R4: After reset is released, sdout_oe_o stays low and sdout_o stays low for STRAP_CYCLES clock cycles. The level of strap_i is taken at the last of those cycles (1 = I2S, 0 = left-justified), and sdout_oe_o then rises and stays high.
- R5: Master mode (master_i = 1): sclk_o has a period of 2*SCLK_HALF system clocks. lrck_o and sdout_o change only when sclk_o falls. Each half-frame lasts 32 bit clocks when frame64_i = 1 and 24 bit clocks otherwise.
- R6: Slave mode (master_i = 0): the block follows the external sclk_i and lrck_i for frames of 48 or 64 bit clocks, and changes the data only after a falling edge of sclk_i.
- R7: Every bit slot of a half-frame after the LSB carries 0.
- R8: A pair offered with valid_i is sent starting at the next left word. ack_o pulses for exactly one cycle when the pair is taken, and only while the output is enabled.
- R9: If no pair has been offered since the last capture, the previous pair is sent again and ack_o stays low.
- R10: During reset ack_o, sclk_o, sdout_o and sdout_oe_o are all 0, and the first frame after start carries zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1: generate bit and word clocks; 0: follow external clocks |
| frame64_i | input | 1 | Master frame length: 1 = 64, 0 = 48 bit clocks |
| left_i | input | WORD_W | Left sample offered |
| right_i | input | WORD_W | Right sample offered |
| valid_i | input | 1 | One-cycle strobe marking a new pair |
| ack_o | output | 1 | Pulse when an offered pair is taken for transmission |
| sclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External word clock (slave) |
| strap_i | input | 1 | Level read back from the data pin |
| sclk_o | output | 1 | Generated bit clock (master, else 0) |
| lrck_o | output | 1 | Generated word clock (master, else 0) |
| sdout_o | output | 1 | Serial data |
| sdout_oe_o | output | 1 | Data pin drive enable |

## Verification
The hardest case to reach is the boundary between a half-frame and the next one in I2S framing with 48-bit frames. There the LSB of one word falls in the first bit slot after the word-clock change, so it is sent while the word clock already marks the other channel. The bench runs both framings with both frame lengths, in master mode and against an external clock source. It decodes the line from the word-clock level seen at each rising bit-clock edge. The repeat case is reached by randomly withholding pairs during some frames. A withheld pair must leave the next frame unchanged and produce no acknowledge.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic {
    FMT_LJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;
endpackage

// File: rtl/stx_strap_ctl.sv
module stx_strap_ctl
  import stx_pkg::*;
#(
  parameter int unsigned STRAP_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic run_o,
  output logic start_o,
  output fmt_e fmt_o
);
  localparam int unsigned CW = (STRAP_CYCLES > 1) ? $clog2(STRAP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRAP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  fmt_e          fmt_q;

  assign start_o = !run_q && (cnt_q == LAST);
  assign run_o   = run_q;
  // before latching, downstream init logic sees the live strap level
  assign fmt_o   = run_q ? fmt_q : fmt_e'(strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      fmt_q <= FMT_LJ;
    end else if (!run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b1;
        fmt_q <= fmt_e'(strap_i);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/stx_clk_front.sv
module stx_clk_front
  import stx_pkg::*;
#(
  parameter int unsigned SCLK_HALF   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SLOTS_SHORT = 24,
  parameter int unsigned SLOTS_LONG  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  input  logic master_i,
  input  logic frame64_i,
  input  fmt_e fmt_i,
  input  logic sclk_i,
  input  logic lrck_i,
  output logic sclk_o,
  output logic lrck_o,
  output logic fall_o,
  output logic lr_o,
  output logic lr_init_o
);
  localparam int unsigned DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int unsigned SW = $clog2(SLOTS_LONG);
  localparam logic [DW-1:0] DIV_LAST   = DW'(SCLK_HALF - 1);
  localparam logic [SW-1:0] LAST_SHORT = SW'(SLOTS_SHORT - 1);
  localparam logic [SW-1:0] LAST_LONG  = SW'(SLOTS_LONG - 1);

  // slave path: synchronisers
  logic [SYNC_STAGES-1:0] sc_sync, lr_sync;
  logic sc_prev, sc_s, lr_s, s_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_sync <= '0;
      lr_sync <= '0;
      sc_prev <= 1'b0;
    end else begin
      sc_sync <= {sc_sync[SYNC_STAGES-2:0], sclk_i};
      lr_sync <= {lr_sync[SYNC_STAGES-2:0], lrck_i};
      sc_prev <= sc_sync[SYNC_STAGES-1];
    end
  end

  assign sc_s   = sc_sync[SYNC_STAGES-1];
  assign lr_s   = lr_sync[SYNC_STAGES-1];
  assign s_fall = run_i && sc_prev && !sc_s;

  // master path: divider and slot counter
  logic [DW-1:0] div_q;
  logic [SW-1:0] slot_q;
  logic sclk_q, lrck_q, first_q, tick, m_fall, wrap, right_lvl;

  assign right_lvl = (fmt_i == FMT_I2S);
  assign tick      = (div_q == DIV_LAST);
  assign m_fall    = run_i && master_i && tick && sclk_q;
  assign wrap      = first_q || (slot_q == (frame64_i ? LAST_LONG : LAST_SHORT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      slot_q  <= '0;
      sclk_q  <= 1'b0;
      lrck_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (start_i) begin
      div_q   <= '0;
      slot_q  <= '0;
      sclk_q  <= 1'b0;
      lrck_q  <= right_lvl;
      first_q <= 1'b1;
    end else if (run_i && master_i) begin
      if (tick) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        if (sclk_q) begin
          first_q <= 1'b0;
          if (wrap) begin
            lrck_q <= ~lrck_q;
            slot_q <= '0;
          end else begin
            slot_q <= slot_q + SW'(1);
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sclk_o    = master_i && sclk_q;
  assign lrck_o    = master_i && lrck_q;
  assign fall_o    = master_i ? m_fall : s_fall;
  assign lr_o      = master_i ? (wrap ? ~lrck_q : lrck_q) : lr_s;
  assign lr_init_o = master_i ? right_lvl : lr_s;
endmodule

// File: rtl/stx_sample_hold.sv
module stx_sample_hold #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] left_now_o,
  output logic [WORD_W-1:0] right_o,
  output logic              ack_o
);
  logic [WORD_W-1:0] pend_l, pend_r, hold_l, hold_r, src_l, src_r;
  logic pend_full, avail, ack_q;

  assign avail = valid_i || pend_full;
  assign src_l = valid_i ? left_i : pend_l;
  assign src_r = valid_i ? right_i : pend_r;
  // the left MSB may leave in the capture cycle itself
  assign left_now_o = (take_i && avail) ? src_l : hold_l;
  assign right_o    = hold_r;
  assign ack_o      = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l    <= '0;
      pend_r    <= '0;
      hold_l    <= '0;
      hold_r    <= '0;
      pend_full <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_q <= take_i && avail;
      if (take_i) begin
        if (avail) begin
          hold_l    <= src_l;
          hold_r    <= src_r;
          pend_full <= 1'b0;
        end
      end else if (valid_i) begin
        pend_l    <= left_i;
        pend_r    <= right_i;
        pend_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stx_frame_tx.sv
module stx_frame_tx
  import stx_pkg::*;
#(
  parameter int unsigned WORD_W     = 24,
  parameter int unsigned SLOTS_LONG = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic              lr_i,
  input  logic              lr_init_i,
  input  fmt_e              fmt_i,
  input  logic [WORD_W-1:0] left_word_i,
  input  logic [WORD_W-1:0] right_word_i,
  output logic              take_o,
  output logic              sdout_o
);
  localparam int unsigned SW = $clog2(SLOTS_LONG + 2);
  localparam logic [SW-1:0] SAT = '1;

  logic lr_d, lr_prev, active, sd_q;
  logic lr_eff, eff_left, edge_w, bit_w;
  logic [SW-1:0] slot_q, slot_nx;
  logic [WORD_W-1:0] word, shifted;

  // I2S is left-justified against the word clock delayed by one bit clock
  assign lr_eff   = (fmt_i == FMT_I2S) ? lr_d : lr_i;
  assign eff_left = (fmt_i == FMT_I2S) ? ~lr_eff : lr_eff;
  assign edge_w   = lr_eff ^ lr_prev;
  assign slot_nx  = edge_w ? '0 : ((slot_q == SAT) ? SAT : slot_q + SW'(1));
  assign word     = eff_left ? left_word_i : right_word_i;
  assign shifted  = word << slot_nx;
  assign bit_w    = (active || edge_w) && (slot_nx < SW'(WORD_W)) && shifted[WORD_W-1];
  assign take_o   = fall_i && edge_w && eff_left;
  assign sdout_o  = sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_d    <= 1'b0;
      lr_prev <= 1'b0;
      slot_q  <= SAT;
      active  <= 1'b0;
      sd_q    <= 1'b0;
    end else if (start_i) begin
      lr_d    <= lr_init_i;
      lr_prev <= lr_init_i;
      slot_q  <= SAT;
      active  <= 1'b0;
      sd_q    <= 1'b0;
    end else if (fall_i) begin
      lr_d    <= lr_i;
      lr_prev <= lr_eff;
      slot_q  <= slot_nx;
      active  <= active || edge_w;
      sd_q    <= bit_w;
    end
  end
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stx_pkg::*;
#(
  parameter int unsigned WORD_W       = 24,
  parameter int unsigned SLOTS_SHORT  = 24,
  parameter int unsigned SLOTS_LONG   = 32,
  parameter int unsigned SCLK_HALF    = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STRAP_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              frame64_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              valid_i,
  output logic              ack_o,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              strap_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdout_o,
  output logic              sdout_oe_o
);
  logic run, start, fall, lr, lr_init, take;
  fmt_e fmt;
  logic [WORD_W-1:0] left_now, right_word;

  stx_strap_ctl #(.STRAP_CYCLES(STRAP_CYCLES)) u_strap (
    .clk_i, .rst_ni, .strap_i,
    .run_o(run), .start_o(start), .fmt_o(fmt)
  );

  stx_clk_front #(
    .SCLK_HALF(SCLK_HALF), .SYNC_STAGES(SYNC_STAGES),
    .SLOTS_SHORT(SLOTS_SHORT), .SLOTS_LONG(SLOTS_LONG)
  ) u_front (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .master_i, .frame64_i,
    .fmt_i(fmt), .sclk_i, .lrck_i, .sclk_o, .lrck_o,
    .fall_o(fall), .lr_o(lr), .lr_init_o(lr_init)
  );

  stx_sample_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i, .rst_ni, .valid_i, .left_i, .right_i, .take_i(take),
    .left_now_o(left_now), .right_o(right_word), .ack_o
  );

  stx_frame_tx #(.WORD_W(WORD_W), .SLOTS_LONG(SLOTS_LONG)) u_frame (
    .clk_i, .rst_ni, .start_i(start), .fall_i(fall), .lr_i(lr),
    .lr_init_i(lr_init), .fmt_i(fmt), .left_word_i(left_now),
    .right_word_i(right_word), .take_o(take), .sdout_o
  );

  assign sdout_oe_o = run;
endmodule

// File: rtl/stx_chk.sv
module stx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic sclk_o,
  input logic lrck_o,
  input logic sdout_o,
  input logic sdout_oe_o,
  input logic ack_o
);
  assert_quiet_pin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdout_oe_o |-> !sdout_o);
  assert_oe_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdout_oe_o |=> sdout_oe_o);
  assert_lrck_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(sdout_oe_o) && !$stable(lrck_o)) |-> $fell(sclk_o));
  assert_data_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !$stable(sdout_o)) |-> $fell(sclk_o));
  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_ack_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> sdout_oe_o);
endmodule

bind stereo_ser_tx stx_chk u_chk (
  .clk_i, .rst_ni, .master_i, .sclk_o, .lrck_o, .sdout_o, .sdout_oe_o, .ack_o
);

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;
  localparam int W = 24;
  localparam int SCLK_HALF = 2;
  localparam int STRAP = 8;
  localparam int NF = 6;
  localparam int SL_HALF = 6;

  logic clk = 0, rst_n = 0;
  logic master = 0, frame64 = 0, valid = 0;
  logic [W-1:0] left = '0, right = '0;
  logic sclk_drv = 1, lrck_drv = 0, strap_pull = 0;
  logic ack, sclk_o, lrck_o, sdout, oe, strap;

  always #5 clk = ~clk;
  assign strap = oe ? sdout : strap_pull;

  stereo_ser_tx #(.WORD_W(W), .SCLK_HALF(SCLK_HALF), .STRAP_CYCLES(STRAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .frame64_i(frame64),
    .left_i(left), .right_i(right), .valid_i(valid), .ack_o(ack),
    .sclk_i(sclk_drv), .lrck_i(lrck_drv), .strap_i(strap),
    .sclk_o(sclk_o), .lrck_o(lrck_o), .sdout_o(sdout), .sdout_oe_o(oe)
  );

  int tests = 0, fails = 0, cyc_total = 0;
  logic wd = 0;
  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000) wd <= 1;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor state
  logic cfg_i2s = 0, cfg_skip = 0, mon_en = 0, started = 0;
  logic sc_last = 0, lr_hist = 0, last_eff = 0, send_pending = 0;
  int pos = 0, hb = 24, frames = 0, sends = 0, acks = 0, rises = 0, cyc = 0;
  logic [W-1:0] sh = '0, rx_l = '0, cur_l = '0, cur_r = '0, next_l = '0, next_r = '0;

  always @(negedge clk) begin
    logic sc, lr, eff, left_lvl;
    sc = master ? sclk_o : sclk_drv;
    lr = master ? lrck_o : lrck_drv;
    left_lvl = !cfg_i2s;
    if (ack) acks++;
    cyc++;
    if (mon_en && sc && !sc_last) begin
      if (master) begin
        if (rises > 0) chk(cyc == 2*SCLK_HALF, "R5", "sclk period", cyc, 2*SCLK_HALF);
        rises++;
        cyc = 0;
      end
      eff = cfg_i2s ? lr_hist : lr;   // I2S: word one bit clock behind the word clock
      lr_hist = lr;
      if (eff != last_eff) begin
        if (started) chk(pos + 1 == hb, master ? "R5" : "R6", "half-frame length", pos + 1, hb);
        started = 1;
        pos = 0;
        last_eff = eff;
        if (eff == left_lvl) begin cur_l = next_l; cur_r = next_r; end
      end else pos++;
      if (started) begin
        if (pos < W) begin
          sh = {sh[W-2:0], sdout};
          if (pos == W-1) begin
            if (eff == left_lvl) begin
              rx_l = sh;
              if (frames < NF-1 && !(cfg_skip && ($urandom % 3 == 0))) send_pending = 1;
            end else begin
              chk(rx_l == cur_l, cfg_i2s ? "R1 R3" : "R1 R2", "left word", rx_l, cur_l);
              chk(sh == cur_r, cfg_i2s ? "R1 R3" : "R1 R2", "right word", sh, cur_r);
              frames++;
            end
          end
        end else begin
          chk(sdout == 1'b0, "R7", "tail slot", sdout, 0);
        end
      end
    end
    sc_last = sc;
  end

  // feeder
  initial begin
    forever begin
      @(negedge clk);
      valid = 0;
      if (send_pending) begin
        left = W'($urandom);
        right = W'($urandom);
        valid = 1;
        next_l = left;
        next_r = right;
        send_pending = 0;
        sends++;
      end
    end
  end

  task automatic run_cfg(input logic m, input logic i2s, input logic f64, input logic skip);
    rst_n = 0;
    mon_en = 0;
    master = m; frame64 = f64; cfg_i2s = i2s; cfg_skip = skip;
    strap_pull = i2s;
    lrck_drv = i2s;      // right-channel level for the chosen framing
    sclk_drv = 1;
    repeat (3) @(negedge clk);
    chk(!oe && !ack && !sclk_o && !sdout, "R10", "reset outputs", {oe, ack, sclk_o, sdout}, 0);
    started = 0; pos = 0; frames = 0; sends = 0; acks = 0; rises = 0; cyc = 0;
    last_eff = i2s; lr_hist = i2s; sc_last = m ? 1'b0 : 1'b1;
    cur_l = '0; cur_r = '0; next_l = '0; next_r = '0; send_pending = 0;
    hb = f64 ? 32 : 24;
    rst_n = 1;
    repeat (STRAP - 1) @(negedge clk);
    chk(!oe && !sdout, "R4", "pin undriven in strap window", {oe, sdout}, 0);
    @(negedge clk);
    chk(oe, "R4", "drive after strap window", oe, 1);
    mon_en = 1;
    if (m) begin
      while (frames < NF && !wd) @(negedge clk);
    end else begin
      while (frames < NF && !wd) begin
        for (int s = 0; s < hb; s++) begin
          sclk_drv = 0;
          if (s == 0) lrck_drv = ~lrck_drv;
          repeat (SL_HALF) @(negedge clk);
          sclk_drv = 1;
          repeat (SL_HALF) @(negedge clk);
        end
      end
    end
    repeat (2) @(negedge clk);
    mon_en = 0;
    chk(acks == sends, skip ? "R9" : "R8", "acknowledge count", acks, sends);
  endtask

  initial begin
    void'($urandom(32'd7021));
    run_cfg(1, 0, 1, 0);   // master, left-justified, 64
    run_cfg(1, 1, 0, 0);   // master, I2S, 48 (LSB crosses the word-clock edge)
    run_cfg(0, 0, 1, 0);   // slave, left-justified, 64
    run_cfg(0, 1, 0, 0);   // slave, I2S, 48
    run_cfg(1, 1, 1, 1);   // master, I2S, 64, withheld pairs
    run_cfg(0, 0, 0, 1);   // slave, left-justified, 48, withheld pairs
    if (wd) chk(0, "watchdog", "run did not complete", cyc_total, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule